// File: doc/BRIEF.md
# MESI Snooping Coherence Cluster

This block keeps a group of small write-back caches coherent. Each cache has its own controller. The controller tracks one of four states for every line it holds: Invalid, Shared, Exclusive or Modified. All controllers sit on one shared broadcast bus that every peer snoops.

A core issues a read, a write or a write-back request and holds it until the request completes. Hits that need no coordination finish locally. Misses, upgrades and write-backs become bus transactions. A fixed-priority arbiter grants the bus to one controller at a time, and each transaction takes exactly one cycle. In that cycle every other controller looks up the addressed line, reports whether it holds a copy, and supplies its data if the copy is Modified. Each controller then updates its state at the same clock edge. A small backing store holds one word per line. It takes the data of every write-back and every modified line that a snoop forces out.

Lines are addressed directly by index, one word per line. The number of caches, the number of lines and the word width are parameters.

Top module: `mesi_coherence_cluster`

## Requirements
- R1: After synchronous reset every line of every cache is Invalid (state code 0), the bus is idle, and the backing store holds zero for every line.
- R2: A read to a line that is Invalid locally and held by no peer issues a bus read (op code 1). It installs the line as Exclusive (code 2) with the backing-store data.
- R3: A bus read of a line that a peer holds in any valid state raises the shared response. Both the peer and the reader end up Shared (code 1). If the peer's copy was Modified (code 3), the peer's data goes to the reader and to the backing store in that same cycle.
- R4: A write to a locally Exclusive line turns it Modified and stores the new word with no bus transaction. The request completes in the cycle after it is presented.
- R5: A write to a locally Shared line issues an invalidate (op code 3). The writer becomes Modified with the new word and every peer copy becomes Invalid.
- R6: A write to a locally Invalid line issues a read-for-ownership (op code 2). The writer becomes Modified with the new word and every peer copy becomes Invalid.
- R7: A read of a line whose copy was invalidated misses and fetches the latest written data over the bus.
- R8: A write-back request on a Modified line issues a write-back (op code 4) and copies the word to the backing store. The line stays Modified. A write-back request on a line that is not Modified completes with no bus transaction.
- R9: A read that hits a valid local line returns the local word with no bus transaction and no state change.
- R10: When several controllers need the bus in the same cycle, the lowest-numbered one wins. At most one transaction occurs per cycle, and each granted request is carried out once.
- R11: When a local request and a peer's snooped read, read-for-ownership or invalidate target the same line in the same cycle, the snoop takes effect first. The local request is evaluated again in a later cycle against the new state.
- R12: A write waiting to upgrade a Shared line that a peer invalidates before the grant is issued as a read-for-ownership instead.
- Request kind codes: 0 read, 1 write, 2 write-back. The state of line l in cache c is reported at bits [(c*LINES+l)*2 +: 2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Per-core request present, held until done |
| req_kind | input | 2*NCORE | Per-core request kind (0 read, 1 write, 2 write-back) |
| req_line | input | LW*NCORE | Per-core line index |
| req_wdata | input | DW*NCORE | Per-core write word |
| req_done | output | NCORE | One-cycle completion pulse per core |
| rsp_data | output | DW*NCORE | Per-core read result, valid with done of a read |
| line_state | output | 2*NLINES*NCORE | State of every line of every cache |
| bus_valid | output | 1 | A transaction is on the bus this cycle |
| bus_op | output | 3 | Transaction code (1 read, 2 read-for-ownership, 3 invalidate, 4 write-back) |
| bus_src | output | SW | Index of the granted controller |
| bus_line | output | LW | Line addressed by the transaction |
| bus_shared | output | 1 | Shared response for a bus read |

## Verification
Two things can land on the same line in the same clock: a controller acting on a local hit and the same controller snooping a peer's transaction. The bench sets this up by starting a peer's read miss on a line one cycle before presenting a silent Exclusive-to-Modified write on that line. The write therefore arrives exactly while the peer's read is on the bus. The bench expects the read to win. The writer must drop to Shared, then issue an invalidate, and the reader must end Invalid. A second collision comes from two simultaneous upgrades of one Shared line. The losing upgrade has to turn into a read-for-ownership. A cycle-accurate reference model judges every clock, and directed checks cover the final states and data.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_RD   = 3'd1,
        OP_RDX  = 3'd2,
        OP_UPG  = 3'd3,
        OP_WB   = 3'd4
    } bop_e;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_WBACK = 2'd2,
        K_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_BUS  = 2'd1,
        F_DONE = 2'd2
    } fsm_e;

    // Bus transaction a request of kind k needs when the local line is in state s
    function automatic bop_e needed_op(kind_e k, mesi_e s);
        bop_e r;
        r = OP_NONE;
        case (k)
            K_READ:  r = (s == ST_I) ? OP_RD : OP_NONE;
            K_WRITE: r = (s == ST_I) ? OP_RDX : ((s == ST_S) ? OP_UPG : OP_NONE);
            K_WBACK: r = (s == ST_M) ? OP_WB : OP_NONE;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

    // State of a peer copy after it snoops transaction op
    function automatic mesi_e snoop_next(bop_e op, mesi_e s);
        mesi_e r;
        r = s;
        case (op)
            OP_RD:          r = (s == ST_I) ? ST_I : ST_S;
            OP_RDX, OP_UPG: r = ST_I;
            default:        r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mesi_arbiter.sv
module mesi_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    a_r10_single_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
    a_r10_no_idle_bus: assert property (@(posedge clk) disable iff (rst) (|req) |-> (|gnt));

endmodule

// File: rtl/mesi_snoop_bus.sv
module mesi_snoop_bus
    import mesi_pkg::*;
#(
    parameter int NCORE  = 3,
    parameter int NLINES = 4,
    parameter int DW     = 8,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] gnt,
    input  bop_e             req_op   [NCORE],
    input  logic [LW-1:0]    req_line [NCORE],
    input  logic [DW-1:0]    req_data [NCORE],
    input  logic [NCORE-1:0] snp_hit,
    input  logic [NCORE-1:0] snp_dirty,
    input  logic [DW-1:0]    snp_data [NCORE],
    output logic             bc_valid,
    output bop_e             bc_op,
    output logic [SW-1:0]    bc_src,
    output logic [LW-1:0]    bc_line,
    output logic [DW-1:0]    bc_data,
    output logic             bc_shared
);
    logic [DW-1:0] mem_q [NLINES];
    logic [DW-1:0] flush_data;
    logic [DW-1:0] src_data;
    logic          any_dirty;

    always_comb begin
        bc_valid = 1'b0;
        bc_op    = OP_NONE;
        bc_src   = '0;
        bc_line  = '0;
        src_data = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (gnt[i]) begin
                bc_valid = 1'b1;
                bc_op    = req_op[i];
                bc_src   = SW'(i);
                bc_line  = req_line[i];
                src_data = req_data[i];
            end
        end
    end

    always_comb begin
        flush_data = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (snp_dirty[i]) flush_data |= snp_data[i];
        end
    end

    assign any_dirty = |snp_dirty;
    assign bc_shared = bc_valid && (bc_op == OP_RD) && (|snp_hit);
    assign bc_data   = any_dirty ? flush_data : mem_q[bc_line];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) mem_q[i] <= '0;
        end else if (bc_valid) begin
            if (bc_op == OP_WB) mem_q[bc_line] <= src_data;
            else if (any_dirty) mem_q[bc_line] <= flush_data;
        end
    end

    // R3: at most one Modified holder of any line
    a_r3_one_dirty_holder: assert property (@(posedge clk) disable iff (rst) $countones(snp_dirty) <= 1);
    // R5: an upgrading writer holds Shared, so no peer can be Modified
    a_r5_upgrade_no_dirty: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_op == OP_UPG) |-> !any_dirty);
    a_r10_snoop_needs_bus: assert property (@(posedge clk) disable iff (rst)
        !bc_valid |-> (snp_hit == '0));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NCORE  = 3,
    parameter int NLINES = 4,
    parameter int DW     = 8,
    parameter int ID     = 0,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [LW-1:0]       req_line,
    input  logic [DW-1:0]       req_wdata,
    output logic                req_done,
    output logic [DW-1:0]       rsp_data,
    output logic                bus_req,
    output bop_e                bus_op,
    output logic [LW-1:0]       bus_line,
    output logic [DW-1:0]       bus_data,
    input  logic                bus_gnt,
    input  logic                bc_valid,
    input  bop_e                bc_op,
    input  logic [SW-1:0]       bc_src,
    input  logic [LW-1:0]       bc_line,
    input  logic [DW-1:0]       bc_data,
    input  logic                bc_shared,
    output logic                snp_hit,
    output logic                snp_dirty,
    output logic [DW-1:0]       snp_data,
    output logic [2*NLINES-1:0] line_states
);
    mesi_e         st_q  [NLINES];
    logic [DW-1:0] dat_q [NLINES];
    fsm_e          fsm_q;
    kind_e         kind_q;
    logic [LW-1:0] line_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rsp_q;

    kind_e req_k;
    bop_e  idle_need;
    bop_e  wait_need;
    logic  snp_act;
    logic  defer;

    assign req_k     = kind_e'(req_kind);
    assign snp_act   = bc_valid && (bc_src != SW'(ID))
                       && (bc_op == OP_RD || bc_op == OP_RDX || bc_op == OP_UPG);
    assign defer     = snp_act && (bc_line == req_line);
    assign idle_need = needed_op(req_k, st_q[req_line]);
    assign wait_need = needed_op(kind_q, st_q[line_q]);

    assign snp_hit   = snp_act && (st_q[bc_line] != ST_I);
    assign snp_dirty = snp_act && (st_q[bc_line] == ST_M);
    assign snp_data  = dat_q[bc_line];

    assign bus_req   = (fsm_q == F_BUS) && (wait_need != OP_NONE);
    assign bus_op    = wait_need;
    assign bus_line  = line_q;
    assign bus_data  = (wait_need == OP_WB) ? dat_q[line_q] : wdata_q;

    assign req_done  = (fsm_q == F_DONE);
    assign rsp_data  = rsp_q;

    for (genvar l = 0; l < NLINES; l++) begin : g_state_out
        assign line_states[2*l +: 2] = st_q[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]  <= ST_I;
                dat_q[i] <= '0;
            end
            fsm_q   <= F_IDLE;
            kind_q  <= K_READ;
            line_q  <= '0;
            wdata_q <= '0;
            rsp_q   <= '0;
        end else begin
            // snooped peer transaction
            if (snp_act && st_q[bc_line] != ST_I)
                st_q[bc_line] <= snoop_next(bc_op, st_q[bc_line]);

            case (fsm_q)
                F_IDLE: begin
                    if (req_valid && !defer) begin
                        kind_q  <= req_k;
                        line_q  <= req_line;
                        wdata_q <= req_wdata;
                        if (idle_need == OP_NONE) begin
                            if (req_k == K_READ) begin
                                rsp_q <= dat_q[req_line];
                            end else if (req_k == K_WRITE) begin
                                st_q[req_line]  <= ST_M;
                                dat_q[req_line] <= req_wdata;
                            end
                            fsm_q <= F_DONE;
                        end else begin
                            fsm_q <= F_BUS;
                        end
                    end
                end
                F_BUS: begin
                    if (wait_need == OP_NONE) begin
                        fsm_q <= F_DONE;
                    end else if (bus_gnt) begin
                        case (wait_need)
                            OP_RD: begin
                                st_q[line_q]  <= bc_shared ? ST_S : ST_E;
                                dat_q[line_q] <= bc_data;
                                rsp_q         <= bc_data;
                            end
                            OP_RDX, OP_UPG: begin
                                st_q[line_q]  <= ST_M;
                                dat_q[line_q] <= wdata_q;
                            end
                            default: ;
                        endcase
                        fsm_q <= F_DONE;
                    end
                end
                default: fsm_q <= F_IDLE;
            endcase
        end
    end

    a_r10_grant_only_when_asking: assert property (@(posedge clk) disable iff (rst)
        bus_gnt |-> bus_req);
    a_r4_silent_upgrade: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == F_IDLE && req_valid && !defer && req_k == K_WRITE && st_q[req_line] == ST_E)
        |=> (st_q[line_q] == ST_M && fsm_q == F_DONE && !bc_valid));
    a_r8_wb_keeps_modified: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && bus_op == OP_WB) |=> st_q[line_q] == ST_M);
    a_r2_fill_exclusive: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && bus_op == OP_RD && !bc_shared) |=> st_q[line_q] == ST_E);
    a_r11_defer_holds: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == F_IDLE && req_valid && defer) |=> fsm_q == F_IDLE);

    for (genvar l = 0; l < NLINES; l++) begin : g_chk
        a_r5_snoop_invalidates: assert property (@(posedge clk) disable iff (rst)
            (snp_act && bc_line == LW'(l) && (bc_op == OP_RDX || bc_op == OP_UPG))
            |=> st_q[l] == ST_I);
        a_r3_snoop_read_shares: assert property (@(posedge clk) disable iff (rst)
            (snp_act && bc_line == LW'(l) && bc_op == OP_RD && st_q[l] != ST_I)
            |=> st_q[l] == ST_S);
    end

endmodule

// File: rtl/mesi_coherence_cluster.sv
module mesi_coherence_cluster
    import mesi_pkg::*;
#(
    parameter int NCORE  = 3,
    parameter int NLINES = 4,
    parameter int DW     = 8,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCORE-1:0]          req_valid,
    input  logic [2*NCORE-1:0]        req_kind,
    input  logic [LW*NCORE-1:0]       req_line,
    input  logic [DW*NCORE-1:0]       req_wdata,
    output logic [NCORE-1:0]          req_done,
    output logic [DW*NCORE-1:0]       rsp_data,
    output logic [2*NLINES*NCORE-1:0] line_state,
    output logic                      bus_valid,
    output logic [2:0]                bus_op,
    output logic [SW-1:0]             bus_src,
    output logic [LW-1:0]             bus_line,
    output logic                      bus_shared
);
    logic [NCORE-1:0] core_req;
    logic [NCORE-1:0] core_gnt;
    logic [NCORE-1:0] snp_hit;
    logic [NCORE-1:0] snp_dirty;
    bop_e             core_op   [NCORE];
    logic [LW-1:0]    core_line [NCORE];
    logic [DW-1:0]    core_data [NCORE];
    logic [DW-1:0]    snp_data  [NCORE];

    logic             bc_valid;
    bop_e             bc_op;
    logic [SW-1:0]    bc_src;
    logic [LW-1:0]    bc_line;
    logic [DW-1:0]    bc_data;
    logic             bc_shared;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        mesi_line_ctrl #(
            .NCORE(NCORE), .NLINES(NLINES), .DW(DW), .ID(c)
        ) i_ctrl (
            .clk        (clk),
            .rst        (rst),
            .req_valid  (req_valid[c]),
            .req_kind   (req_kind[2*c +: 2]),
            .req_line   (req_line[LW*c +: LW]),
            .req_wdata  (req_wdata[DW*c +: DW]),
            .req_done   (req_done[c]),
            .rsp_data   (rsp_data[DW*c +: DW]),
            .bus_req    (core_req[c]),
            .bus_op     (core_op[c]),
            .bus_line   (core_line[c]),
            .bus_data   (core_data[c]),
            .bus_gnt    (core_gnt[c]),
            .bc_valid   (bc_valid),
            .bc_op      (bc_op),
            .bc_src     (bc_src),
            .bc_line    (bc_line),
            .bc_data    (bc_data),
            .bc_shared  (bc_shared),
            .snp_hit    (snp_hit[c]),
            .snp_dirty  (snp_dirty[c]),
            .snp_data   (snp_data[c]),
            .line_states(line_state[2*NLINES*c +: 2*NLINES])
        );
    end

    mesi_arbiter #(.N(NCORE)) i_arb (
        .clk(clk),
        .rst(rst),
        .req(core_req),
        .gnt(core_gnt)
    );

    mesi_snoop_bus #(.NCORE(NCORE), .NLINES(NLINES), .DW(DW)) i_bus (
        .clk      (clk),
        .rst      (rst),
        .gnt      (core_gnt),
        .req_op   (core_op),
        .req_line (core_line),
        .req_data (core_data),
        .snp_hit  (snp_hit),
        .snp_dirty(snp_dirty),
        .snp_data (snp_data),
        .bc_valid (bc_valid),
        .bc_op    (bc_op),
        .bc_src   (bc_src),
        .bc_line  (bc_line),
        .bc_data  (bc_data),
        .bc_shared(bc_shared)
    );

    assign bus_valid  = bc_valid;
    assign bus_op     = bc_op;
    assign bus_src    = bc_src;
    assign bus_line   = bc_line;
    assign bus_shared = bc_shared;

endmodule

// File: tb/test_mesi_coherence_cluster.sv
module test_mesi_coherence_cluster;
    localparam int NC = 3;
    localparam int NL = 4;
    localparam int DW = 8;
    localparam int LW = 2;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic            rv  [NC];
    logic [1:0]      rk  [NC];
    logic [LW-1:0]   rl  [NC];
    logic [DW-1:0]   rwd [NC];

    logic [NC-1:0]       req_valid;
    logic [2*NC-1:0]     req_kind;
    logic [LW*NC-1:0]    req_line;
    logic [DW*NC-1:0]    req_wdata;
    logic [NC-1:0]       req_done;
    logic [DW*NC-1:0]    rsp_data;
    logic [2*NL*NC-1:0]  line_state;
    logic                bus_valid;
    logic [2:0]          bus_op;
    logic [SW-1:0]       bus_src;
    logic [LW-1:0]       bus_line;
    logic                bus_shared;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            req_valid[c]          = rv[c];
            req_kind[2*c +: 2]    = rk[c];
            req_line[LW*c +: LW]  = rl[c];
            req_wdata[DW*c +: DW] = rwd[c];
        end
    end

    mesi_coherence_cluster #(.NCORE(NC), .NLINES(NL), .DW(DW)) i_mesi_coherence_cluster (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_line(req_line), .req_wdata(req_wdata), .req_done(req_done),
        .rsp_data(rsp_data), .line_state(line_state), .bus_valid(bus_valid),
        .bus_op(bus_op), .bus_src(bus_src), .bus_line(bus_line), .bus_shared(bus_shared)
    );

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int ms [NC][NL];
    int md [NC][NL];
    int mm [NL];
    int ph [NC];
    int mk [NC];
    int ml [NC];
    int mw [NC];
    int mr [NC];

    function automatic int needk(int k, int s);
        if (k == 0) return (s == 0) ? 1 : 0;
        if (k == 1) return (s == 0) ? 2 : ((s == 1) ? 3 : 0);
        if (k == 2) return (s == 3) ? 4 : 0;
        return 0;
    endfunction

    function automatic void bus_view(output int w, output int op, output int ln,
                                     output bit shr, output bit dirty, output int fd);
        w = -1; op = 0; ln = 0; shr = 0; dirty = 0; fd = 0;
        for (int c = NC - 1; c >= 0; c--)
            if (ph[c] == 1 && needk(mk[c], ms[c][ml[c]]) != 0) w = c;
        if (w >= 0) begin
            op = needk(mk[w], ms[w][ml[w]]);
            ln = ml[w];
            for (int c = 0; c < NC; c++) begin
                if (c != w && op != 4) begin
                    if (ms[c][ln] == 3) begin dirty = 1; fd = md[c][ln]; end
                    if (ms[c][ln] != 0) shr = 1;
                end
            end
        end
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            for (int l = 0; l < NL; l++) begin ms[c][l] = 0; md[c][l] = 0; end
            ph[c] = 0; mk[c] = 0; ml[c] = 0; mw[c] = 0; mr[c] = 0;
        end
        for (int l = 0; l < NL; l++) mm[l] = 0;
    endtask

    task automatic model_step();
        int w, op, ln, fd, bd;
        bit shr, dirty;
        int nms [NC][NL];
        int nmd [NC][NL];
        int nmm [NL];
        int nph [NC];
        nms = ms; nmd = md; nmm = mm; nph = ph;
        bus_view(w, op, ln, shr, dirty, fd);
        bd = dirty ? fd : mm[ln];
        if (w >= 0) begin
            if (op == 4) nmm[ln] = md[w][ln];
            else if (dirty) nmm[ln] = fd;
            if (op != 4)
                for (int c = 0; c < NC; c++)
                    if (c != w && ms[c][ln] != 0) nms[c][ln] = (op == 1) ? 1 : 0;
            if (op == 1) begin nms[w][ln] = shr ? 1 : 2; nmd[w][ln] = bd; mr[w] = bd; end
            else if (op == 2 || op == 3) begin nms[w][ln] = 3; nmd[w][ln] = mw[w]; end
            nph[w] = 2;
        end
        for (int c = 0; c < NC; c++) begin
            if (ph[c] == 2) nph[c] = 0;
            else if (ph[c] == 1) begin
                if (c != w && needk(mk[c], ms[c][ml[c]]) == 0) nph[c] = 2;
            end else if (rv[c] && !(w >= 0 && w != c && op != 4 && ln == int'(rl[c]))) begin
                mk[c] = rk[c]; ml[c] = rl[c]; mw[c] = rwd[c];
                if (needk(rk[c], ms[c][rl[c]]) == 0) begin
                    if (rk[c] == 0) mr[c] = md[c][rl[c]];
                    else if (rk[c] == 1) begin nms[c][rl[c]] = 3; nmd[c][rl[c]] = rwd[c]; end
                    nph[c] = 2;
                end else nph[c] = 1;
            end
        end
        ms = nms; md = nmd; mm = nmm; ph = nph;
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else model_step();
    end

    // per-cycle comparison and bus log, away from the active edge
    int bus_cnt = 0;
    int src_log[$];
    int op_log[$];

    always @(negedge clk) begin
        if (!rst && !ended) begin
            int w, op, ln, fd;
            bit shr, dirty, bad;
            bad = 0;
            bus_view(w, op, ln, shr, dirty, fd);
            for (int c = 0; c < NC; c++) begin
                for (int l = 0; l < NL; l++)
                    if (int'(line_state[(c*NL+l)*2 +: 2]) != ms[c][l]) bad = 1;
                if (req_done[c] != (ph[c] == 2)) bad = 1;
                if (req_done[c] && mk[c] == 0 && int'(rsp_data[DW*c +: DW]) != mr[c]) bad = 1;
            end
            if (bus_valid != (w >= 0)) bad = 1;
            if (w >= 0 && (int'(bus_op) != op || int'(bus_src) != w ||
                           int'(bus_line) != ln || bus_shared != (op == 1 && shr))) bad = 1;
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL R10 model mismatch at %0t actual bus op %0d src %0d expected op %0d src %0d",
                         $time, bus_op, bus_src, op, w);
            end
            if (bus_valid) begin
                bus_cnt++;
                src_log.push_back(int'(bus_src));
                op_log.push_back(int'(bus_op));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int last_rsp [NC];

    task automatic issue(int c, int k, int l, int d);
        @(negedge clk);
        rv[c] = 1'b1; rk[c] = 2'(k); rl[c] = LW'(l); rwd[c] = DW'(d);
        do @(negedge clk); while (!req_done[c]);
        last_rsp[c] = int'(rsp_data[DW*c +: DW]);
        rv[c] = 1'b0;
    endtask

    function automatic int st(int c, int l);
        return int'(line_state[(c*NL+l)*2 +: 2]);
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        int base;
        for (int c = 0; c < NC; c++) begin rv[c] = 0; rk[c] = 0; rl[c] = 0; rwd[c] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++) chk("R1 state after reset", st(c, l), 0);
        chk("R1 bus idle after reset", int'(bus_valid), 0);

        // R2: clean read miss installs Exclusive
        base = bus_cnt;
        issue(0, 0, 1, 0);
        chk("R2 read miss data", last_rsp[0], 0);
        chk("R2 state Exclusive", st(0, 1), 2);
        chk("R2 one bus read", bus_cnt - base, 1);
        chk("R2 op code", op_log[$], 1);

        // R4: silent Exclusive to Modified
        base = bus_cnt;
        issue(0, 1, 1, 'h5A);
        chk("R4 state Modified", st(0, 1), 3);
        chk("R4 no bus traffic", bus_cnt - base, 0);

        // R3: peer read of a Modified line
        issue(1, 0, 1, 0);
        chk("R3 reader gets dirty data", last_rsp[1], 'h5A);
        chk("R3 holder Shared", st(0, 1), 1);
        chk("R3 reader Shared", st(1, 1), 1);

        // R5: write to Shared invalidates peers
        issue(0, 1, 1, 'h77);
        chk("R5 invalidate op", op_log[$], 3);
        chk("R5 writer Modified", st(0, 1), 3);
        chk("R5 peer Invalid", st(1, 1), 0);

        // R7: read after invalidation fetches latest
        issue(1, 0, 1, 0);
        chk("R7 refetched data", last_rsp[1], 'h77);
        chk("R7 reader Shared", st(1, 1), 1);

        // R6: write miss uses read-for-ownership
        issue(2, 1, 2, 'h33);
        chk("R6 rfo op", op_log[$], 2);
        chk("R6 writer Modified", st(2, 2), 3);

        // R8: write-back of Modified keeps state; of Shared does nothing on bus
        base = bus_cnt;
        issue(2, 2, 2, 0);
        chk("R8 write-back op", op_log[$], 4);
        chk("R8 one transaction", bus_cnt - base, 1);
        chk("R8 still Modified", st(2, 2), 3);
        base = bus_cnt;
        issue(1, 2, 1, 0);
        chk("R8 clean write-back silent", bus_cnt - base, 0);
        chk("R8 clean line unchanged", st(1, 1), 1);
        issue(0, 0, 2, 0);
        chk("R3 read sees written data", last_rsp[0], 'h33);
        chk("R3 writer demoted Shared", st(2, 2), 1);

        // R9: read hit
        base = bus_cnt;
        issue(1, 0, 1, 0);
        chk("R9 hit data", last_rsp[1], 'h77);
        chk("R9 no bus traffic", bus_cnt - base, 0);
        chk("R9 state kept", st(1, 1), 1);

        // R10: three simultaneous misses
        src_log.delete();
        fork
            issue(0, 0, 0, 0);
            issue(1, 0, 3, 0);
            issue(2, 0, 0, 0);
        join
        chk("R10 transactions", src_log.size(), 3);
        if (src_log.size() == 3) begin
            chk("R10 first winner", src_log[0], 0);
            chk("R10 second winner", src_log[1], 1);
            chk("R10 third winner", src_log[2], 2);
        end
        chk("R10 shared copies c0", st(0, 0), 1);
        chk("R10 shared copies c2", st(2, 0), 1);
        chk("R10 lone copy Exclusive", st(1, 3), 2);

        // R11: local silent write collides with peer read of same line
        op_log.delete();
        fork
            issue(0, 0, 3, 0);
            begin @(negedge clk); issue(1, 1, 3, 'hC4); end
        join
        chk("R11 reader data", last_rsp[0], 0);
        chk("R11 reader invalidated", st(0, 3), 0);
        chk("R11 writer Modified", st(1, 3), 3);
        chk("R11 writer had to invalidate", op_log.size(), 2);
        if (op_log.size() == 2) chk("R11 second op is invalidate", op_log[1], 3);

        // R12: two upgrades race for one Shared line
        op_log.delete();
        src_log.delete();
        fork
            issue(0, 1, 1, 'h11);
            issue(1, 1, 1, 'h22);
        join
        chk("R12 two transactions", op_log.size(), 2);
        if (op_log.size() == 2) begin
            chk("R12 winner upgrades", op_log[0], 3);
            chk("R12 loser becomes rfo", op_log[1], 2);
            chk("R12 loser is core 1", src_log[1], 1);
        end
        chk("R12 winner now Invalid", st(0, 1), 0);
        chk("R12 loser Modified", st(1, 1), 3);
        issue(2, 0, 1, 0);
        chk("R12 final data", last_rsp[2], 'h22);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule